// File: doc/BRIEF.md
# Twofish Round F-Function

This block evaluates the keyed round function of a 128-bit-block Feistel cipher built from two parallel g transforms. Each cycle in which `in_vld` is high it takes the two left-half words of the Feistel state (`r0`, `r1`), the two round subkeys (`ka`, `kb`) and the two S-box key words (`sk_hi`, `sk_lo`). One clock later it presents the two 32-bit round outputs. The surrounding datapath owns the subkey generation, the XOR into the right half and the round sequencing.

Each g transform substitutes the four bytes of its word through key-dependent 8-bit S-boxes. Each S-box is three stages of the fixed permutations q0/q1, with a key byte XORed in between the stages. The four substituted bytes are then diffused by a 4×4 MDS matrix over GF(2^8). The second g transform sees its word rotated left by 8 bits. The two results T0 and T1 are merged by a pseudo-Hadamard transform, and the subkeys are added.

Top module: `twf_round_f`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld`, `f0` and `f1` are driven to zero at that edge.
- R2: `out_vld` is high in exactly the cycle after a cycle in which `in_vld` was sampled high. The results of that sample appear on `f0`/`f1` in the same cycle.
- R3: When `in_vld` is low, `f0` and `f1` keep their previous values whatever the other inputs do.
- R4: `f0` = T0 + T1 + `ka` mod 2^32, where T0 = g(`r0`) and T1 = g(rotl(`r1`, 8)).
- R5: `f1` = T0 + 2·T1 + `kb` mod 2^32.
- R6: Byte lane i of a g input (lane 0 = bits 7:0) passes through three q stages. Lane 0 uses q0,q0,q1; lane 1 uses q1,q0,q0; lane 2 uses q0,q1,q1; lane 3 uses q1,q1,q0. Byte i of `sk_hi` is XORed in after stage one, and byte i of `sk_lo` after stage two.
- R7: q0 and q1 each split the byte into nibbles and apply two rounds of 4-bit table lookups with nibble mixing, so that q0(0x00)=0xA9 and q1(0x00)=0x75.
- R8: The substituted bytes y0..y3 are multiplied by the matrix with rows (01 EF 5B 5B), (5B EF EF 01), (EF 5B 01 EF) and (EF 01 EF 5B). The field polynomial is x^8+x^6+x^5+x^3+1, and output byte i lands in bits 8i+7:8i.
- R9: The subkeys enter only by addition: raising `ka` by d raises `f0` by d and leaves `f1` unchanged, and likewise for `kb` and `f1`.
- R10: When `r0` equals rotl(`r1`, 8), the two g results are equal, so 2·(`f1`−`kb`) = 3·(`f0`−`ka`) mod 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| r0 | input | 32 | First left-half state word |
| r1 | input | 32 | Second left-half state word |
| ka | input | 32 | Round subkey added into f0 |
| kb | input | 32 | Round subkey added into f1 |
| sk_hi | input | 32 | S-box key word XORed after the first q stage |
| sk_lo | input | 32 | S-box key word XORed after the second q stage |
| out_vld | output | 1 | Results valid |
| f0 | output | 32 | First round output |
| f1 | output | 32 | Second round output |

## Verification
The assertions assume that `in_vld` is a clean 0/1 level once reset is released. They also assume the operands carry no unknown bits in a cycle where `in_vld` is high. The bench meets this by holding `in_vld` low through reset and driving every operand from `$urandom` or fixed constants. The R10 property relies only on the design's own rotation of `r1`. The stimulus therefore builds `r0` from a random `r1` to reach that case on purpose.

// File: rtl/twf_pkg.sv
package twf_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int NIB_W  = BYTE_W / 2;
  // reduction term of x^8 = x^6 + x^5 + x^3 + 1
  localparam logic [BYTE_W-1:0] GF_RED = 8'h69;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NIB_W-1:0]  nib_t;

  // 4-bit lookup tables, entry n held at bits [4n+3:4n]
  localparam logic [63:0] QA_T0 = 64'h4ACE95B023F6D718;
  localparam logic [63:0] QA_T1 = 64'hD9076A4F53218BCE;
  localparam logic [63:0] QA_T2 = 64'h17423F8C09D6E5AB;
  localparam logic [63:0] QA_T3 = 64'hAC5803B9E6214F7D;
  localparam logic [63:0] QB_T0 = 64'h5CA04913E67FDB82;
  localparam logic [63:0] QB_T1 = 64'h809F5AD673C4B2E1;
  localparam logic [63:0] QB_T2 = 64'hF3B28DE0A96157C4;
  localparam logic [63:0] QB_T3 = 64'hA802F746ED3C159B;

  function automatic nib_t nib_ror1(input nib_t n);
    return {n[0], n[NIB_W-1:1]};
  endfunction

  function automatic nib_t nib_look(input logic [63:0] tbl, input nib_t idx);
    return tbl[{idx, 2'b00} +: NIB_W];
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t c);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[i]) acc = acc ^ sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? GF_RED : '0);
    end
    return acc;
  endfunction

  function automatic byte_t mds_coef(input int r, input int c);
    byte_t v;
    case ({r[1:0], c[1:0]})
      4'b0000: v = 8'h01; 4'b0001: v = 8'hEF; 4'b0010: v = 8'h5B; 4'b0011: v = 8'h5B;
      4'b0100: v = 8'h5B; 4'b0101: v = 8'hEF; 4'b0110: v = 8'hEF; 4'b0111: v = 8'h01;
      4'b1000: v = 8'hEF; 4'b1001: v = 8'h5B; 4'b1010: v = 8'h01; 4'b1011: v = 8'hEF;
      4'b1100: v = 8'hEF; 4'b1101: v = 8'h01; 4'b1110: v = 8'hEF; default: v = 8'h5B;
    endcase
    return v;
  endfunction

  function automatic word_t mds_mul(input word_t y);
    word_t z;
    z = '0;
    for (int r = 0; r < LANES; r++) begin
      for (int c = 0; c < LANES; c++) begin
        z[r*BYTE_W +: BYTE_W] = z[r*BYTE_W +: BYTE_W] ^ gf_mul(y[c*BYTE_W +: BYTE_W], mds_coef(r, c));
      end
    end
    return z;
  endfunction

  // stage variants per lane: bit0 first stage, bit2 last stage (1 = q1)
  function automatic logic [2:0] lane_qsel(input int lane);
    case (lane)
      0:       return 3'b100;
      1:       return 3'b001;
      2:       return 3'b110;
      default: return 3'b011;
    endcase
  endfunction
endpackage

// File: rtl/twf_qperm.sv
module twf_qperm
  import twf_pkg::*;
#(
  parameter bit VARIANT = 1'b0
) (
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  localparam logic [63:0] TA = VARIANT ? QB_T0 : QA_T0;
  localparam logic [63:0] TB = VARIANT ? QB_T1 : QA_T1;
  localparam logic [63:0] TC = VARIANT ? QB_T2 : QA_T2;
  localparam logic [63:0] TD = VARIANT ? QB_T3 : QA_T3;

  nib_t hi0, lo0, hi1, lo1, hi2, lo2, hi3, lo3, hi4, lo4;

  always_comb begin
    hi0 = x[BYTE_W-1:NIB_W];
    lo0 = x[NIB_W-1:0];
    hi1 = hi0 ^ lo0;
    lo1 = hi0 ^ nib_ror1(lo0) ^ {hi0[0], 3'b000};
    hi2 = nib_look(TA, hi1);
    lo2 = nib_look(TB, lo1);
    hi3 = hi2 ^ lo2;
    lo3 = hi2 ^ nib_ror1(lo2) ^ {hi2[0], 3'b000};
    hi4 = nib_look(TC, hi3);
    lo4 = nib_look(TD, lo3);
    y   = {lo4, hi4};
  end
endmodule

// File: rtl/twf_sbox_lane.sv
module twf_sbox_lane
  import twf_pkg::*;
#(
  parameter logic [2:0] QSEL = 3'b000
) (
  input  logic [BYTE_W-1:0] x,
  input  logic [BYTE_W-1:0] kh,
  input  logic [BYTE_W-1:0] kl,
  output logic [BYTE_W-1:0] y
);
  byte_t s1, s2, m1, m2;

  twf_qperm #(.VARIANT(QSEL[0])) u_q1 (.x(x),  .y(s1));
  assign m1 = s1 ^ kh;
  twf_qperm #(.VARIANT(QSEL[1])) u_q2 (.x(m1), .y(s2));
  assign m2 = s2 ^ kl;
  twf_qperm #(.VARIANT(QSEL[2])) u_q3 (.x(m2), .y(y));
endmodule

// File: rtl/twf_gfunc.sv
module twf_gfunc
  import twf_pkg::*;
#(
  parameter int ROT = 0
) (
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] sk_hi,
  input  logic [WORD_W-1:0] sk_lo,
  output logic [WORD_W-1:0] t
);
  localparam int RSH = (WORD_W - ROT) % WORD_W;

  word_t xr;
  byte_t sb [LANES];
  word_t sbw;

  assign xr = (x << ROT) | (x >> RSH);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    twf_sbox_lane #(.QSEL(lane_qsel(i))) u_sb (
      .x (xr[i*BYTE_W +: BYTE_W]),
      .kh(sk_hi[i*BYTE_W +: BYTE_W]),
      .kl(sk_lo[i*BYTE_W +: BYTE_W]),
      .y (sb[i])
    );
  end

  always_comb begin
    sbw = '0;
    for (int i = 0; i < LANES; i++) sbw[i*BYTE_W +: BYTE_W] = sb[i];
    t = mds_mul(sbw);
  end
endmodule

// File: rtl/twf_round_f.sv
module twf_round_f
  import twf_pkg::*;
#(
  parameter int ROT1 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] r0,
  input  logic [WORD_W-1:0] r1,
  input  logic [WORD_W-1:0] ka,
  input  logic [WORD_W-1:0] kb,
  input  logic [WORD_W-1:0] sk_hi,
  input  logic [WORD_W-1:0] sk_lo,
  output logic              out_vld,
  output logic [WORD_W-1:0] f0,
  output logic [WORD_W-1:0] f1
);
  word_t t0, t1, sum0, sum1;

  twf_gfunc #(.ROT(0))    u_g0 (.x(r0), .sk_hi(sk_hi), .sk_lo(sk_lo), .t(t0));
  twf_gfunc #(.ROT(ROT1)) u_g1 (.x(r1), .sk_hi(sk_hi), .sk_lo(sk_lo), .t(t1));

  // pseudo-Hadamard merge plus subkeys
  always_comb begin
    sum0 = t0 + t1 + ka;
    sum1 = t0 + (t1 << 1) + kb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      f0      <= '0;
      f1      <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        f0 <= sum0;
        f1 <= sum1;
      end
    end
  end
endmodule

// File: rtl/twf_round_f_chk.sv
module twf_round_f_chk
  import twf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [WORD_W-1:0] r0,
  input logic [WORD_W-1:0] r1,
  input logic [WORD_W-1:0] ka,
  input logic [WORD_W-1:0] kb,
  input logic              out_vld,
  input logic [WORD_W-1:0] f0,
  input logic [WORD_W-1:0] f1
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) $fell(rst) |-> (!out_vld && f0 == '0 && f1 == '0));
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst) out_vld == $past(in_vld));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst) !$past(in_vld) |-> ($stable(f0) && $stable(f1)));
  // R10
  equal_g_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_vld) && $past(r0) == {$past(r1[23:0]), $past(r1[31:24])})
      |-> (((f1 - $past(kb)) << 1) == ((f0 - $past(ka)) * 3)));
endmodule

bind twf_round_f twf_round_f_chk u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .r0(r0), .r1(r1),
  .ka(ka), .kb(kb), .out_vld(out_vld), .f0(f0), .f1(f1)
);

// File: tb/tb_twf_round_f.sv
module tb_twf_round_f;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [31:0] r0 = '0, r1 = '0, ka = '0, kb = '0, sk_hi = '0, sk_lo = '0;
  logic out_vld;
  logic [31:0] f0, f1;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  twf_round_f dut (.*);

  localparam logic [3:0] QT [2][4][16] = '{
    '{ '{4'h8,4'h1,4'h7,4'hD,4'h6,4'hF,4'h3,4'h2,4'h0,4'hB,4'h5,4'h9,4'hE,4'hC,4'hA,4'h4},
       '{4'hE,4'hC,4'hB,4'h8,4'h1,4'h2,4'h3,4'h5,4'hF,4'h4,4'hA,4'h6,4'h7,4'h0,4'h9,4'hD},
       '{4'hB,4'hA,4'h5,4'hE,4'h6,4'hD,4'h9,4'h0,4'hC,4'h8,4'hF,4'h3,4'h2,4'h4,4'h7,4'h1},
       '{4'hD,4'h7,4'hF,4'h4,4'h1,4'h2,4'h6,4'hE,4'h9,4'hB,4'h3,4'h0,4'h8,4'h5,4'hC,4'hA} },
    '{ '{4'h2,4'h8,4'hB,4'hD,4'hF,4'h7,4'h6,4'hE,4'h3,4'h1,4'h9,4'h4,4'h0,4'hA,4'hC,4'h5},
       '{4'h1,4'hE,4'h2,4'hB,4'h4,4'hC,4'h3,4'h7,4'h6,4'hD,4'hA,4'h5,4'hF,4'h9,4'h0,4'h8},
       '{4'h4,4'hC,4'h7,4'h5,4'h1,4'h6,4'h9,4'hA,4'h0,4'hE,4'hD,4'h8,4'h2,4'hB,4'h3,4'hF},
       '{4'hB,4'h9,4'h5,4'h1,4'hC,4'h3,4'hD,4'hE,4'h6,4'h4,4'h7,4'hF,4'h2,4'h0,4'h8,4'hA} }
  };

  localparam logic [7:0] MC [4][4] = '{
    '{8'h01, 8'hEF, 8'h5B, 8'h5B},
    '{8'h5B, 8'hEF, 8'hEF, 8'h01},
    '{8'hEF, 8'h5B, 8'h01, 8'hEF},
    '{8'hEF, 8'h01, 8'hEF, 8'h5B}
  };

  function automatic int ror4(int n);
    return ((n >> 1) | (n << 3)) & 15;
  endfunction

  // R7 reference permutation
  function automatic logic [7:0] m_q(int v, logic [7:0] x);
    int a, b, a2, b2;
    a  = int'(x) >> 4;
    b  = int'(x) & 15;
    a2 = int'(QT[v][0][a ^ b]);
    b2 = int'(QT[v][1][(a ^ ror4(b) ^ ((a * 8) & 15)) & 15]);
    a  = int'(QT[v][2][a2 ^ b2]);
    b  = int'(QT[v][3][(a2 ^ ror4(b2) ^ ((a2 * 8) & 15)) & 15]);
    return 8'((b << 4) | a);
  endfunction

  // R8 field product: carry-less multiply then reduce
  function automatic logic [7:0] m_gmul(logic [7:0] a, logic [7:0] c);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (c[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h0169 << (i - 8));
    return p[7:0];
  endfunction

  // R6 + R8 reference g
  function automatic logic [31:0] m_g(logic [31:0] x, logic [31:0] kh, logic [31:0] kl);
    logic [7:0] y [4];
    logic [31:0] z;
    int sel [4][3] = '{'{0,0,1}, '{1,0,0}, '{0,1,1}, '{1,1,0}};
    for (int i = 0; i < 4; i++) begin
      y[i] = m_q(sel[i][0], x[8*i +: 8]) ^ kh[8*i +: 8];
      y[i] = m_q(sel[i][1], y[i]) ^ kl[8*i +: 8];
      y[i] = m_q(sel[i][2], y[i]);
    end
    z = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        z[8*r +: 8] = z[8*r +: 8] ^ m_gmul(y[c], MC[r][c]);
    return z;
  endfunction

  function automatic logic [63:0] m_f(logic [31:0] a0, logic [31:0] a1, logic [31:0] k0,
                                      logic [31:0] k1, logic [31:0] kh, logic [31:0] kl);
    logic [31:0] t0, t1;
    t0 = m_g(a0, kh, kl);
    t1 = m_g({a1[23:0], a1[31:24]}, kh, kl);
    return {t0 + t1 + t1 + k1, t0 + t1 + k0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic drive(logic [31:0] a0, logic [31:0] a1, logic [31:0] k0,
                       logic [31:0] k1, logic [31:0] kh, logic [31:0] kl);
    @(negedge clk);
    r0 = a0; r1 = a1; ka = k0; kb = k1; sk_hi = kh; sk_lo = kl;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic run_one(string req, logic [31:0] a0, logic [31:0] a1, logic [31:0] k0,
                         logic [31:0] k1, logic [31:0] kh, logic [31:0] kl);
    logic [63:0] e;
    e = m_f(a0, a1, k0, k1, kh, kl);
    drive(a0, a1, k0, k1, kh, kl);
    check({req, " R2 vld"}, 32'(out_vld), 32'd1);
    check({req, " R4 f0"}, f0, e[31:0]);
    check({req, " R5 f1"}, f1, e[63:32]);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1, k0, k1, kh, kl, d, p0, p1;
    void'($urandom(32'h5EED_2F15));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 out_vld", 32'(out_vld), 32'd0);
    check("R1 f0", f0, 32'd0);
    check("R1 f1", f1, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle vld", 32'(out_vld), 32'd0);

    // R7: with zero keys and byte 0 only, lane 0 sees q1(q0(q0(x)))
    check("R7 q0(00)", 32'(m_q(0, 8'h00)), 32'hA9);
    check("R7 q1(00)", 32'(m_q(1, 8'h00)), 32'h75);

    // R6, R8 directed corners
    run_one("zero", '0, '0, '0, '0, '0, '0);
    run_one("ones", '1, '1, '1, '1, '1, '1);
    run_one("lane0", 32'h0000_00FF, 32'h0, 32'h0, 32'h0, 32'h0000_0011, 32'h0);
    run_one("lane3", 32'h0, 32'hFF00_0000, 32'h0, 32'h0, 32'h0, 32'h2200_0000);
    run_one("wrap", 32'h8000_0001, 32'h0102_0304, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hDEAD_BEEF, 32'h0BAD_F00D);

    // R4, R5, R6, R8 random operands
    for (int n = 0; n < 300; n++)
      run_one("rand", $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);

    // R3: inputs change with in_vld low, outputs hold
    a0 = $urandom; a1 = $urandom; kh = $urandom; kl = $urandom;
    run_one("R3 pre", a0, a1, 32'h1, 32'h2, kh, kl);
    p0 = f0; p1 = f1;
    @(negedge clk);
    r0 = ~a0; r1 = ~a1; ka = $urandom; kb = $urandom; sk_hi = ~kh; sk_lo = ~kl;
    repeat (2) @(negedge clk);
    check("R3 f0 hold", f0, p0);
    check("R3 f1 hold", f1, p1);
    check("R3 vld low", 32'(out_vld), 32'd0);

    // R9: subkeys are purely additive
    for (int n = 0; n < 20; n++) begin
      a0 = $urandom; a1 = $urandom; k0 = $urandom; k1 = $urandom;
      kh = $urandom; kl = $urandom; d = $urandom;
      drive(a0, a1, k0, k1, kh, kl);
      p0 = f0; p1 = f1;
      drive(a0, a1, k0 + d, k1, kh, kl);
      check("R9 f0 shift by ka", f0, p0 + d);
      check("R9 f1 untouched by ka", f1, p1);
      drive(a0, a1, k0, k1 + d, kh, kl);
      check("R9 f0 untouched by kb", f0, p0);
      check("R9 f1 shift by kb", f1, p1 + d);
    end

    // R10: equal g results when r0 == rotl(r1, 8)
    for (int n = 0; n < 20; n++) begin
      a1 = $urandom; k0 = $urandom; k1 = $urandom;
      a0 = {a1[23:0], a1[31:24]};
      drive(a0, a1, k0, k1, $urandom, $urandom);
      check("R10 2(f1-kb) vs 3(f0-ka)", (f1 - k1) << 1, (f0 - k0) * 3);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule